// File: doc/BRIEF.md
# Scanline Display Mode Sequencer

This block produces the timing skeleton of a tile-based LCD renderer with a visible area of 160 by 144 pixels. It counts one dot each time the CPU clock enable `tick` is high. A dot counter and a line counter together divide the frame into phases. On each visible line the phases run in a fixed order: object search, pixel transfer, then horizontal blank. After the last visible line, ten lines of vertical blank follow. A complete frame is 154 lines of 456 dots, which is 70,224 ticks.

Downstream logic uses the outputs of this block. The fetch and compose stages use the phase code and the pixel column. The CPU bus arbiter uses a VRAM-lock flag, which is high for the whole of pixel transfer. Three single-cycle strobes mark the start of horizontal blank, the start of vertical blank (the frame can be presented here) and the wrap from the last line back to line 0.

The `lcd_on` input models the display-enable control. While it is low, the sequencer stays at the origin and does nothing. When it is raised, line 0 starts at once in object search.

Top module: `lcd_line_sequencer`

## Requirements
- R1: While `rst_n` is low, `line` is 0, `col_valid` is 0 and all three strobes are 0. `mode` reads 2 if `lcd_on` is high and 0 if it is low.
- R2: Every line lasts exactly 456 ticks. After the 456th tick of a line, `line` advances by one.
- R3: On lines 0 to 143, `mode` encodes the phase as follows. It is 2 (object search) for dots 0 to 79, 3 (pixel transfer) for dots 80 to 251 and 0 (horizontal blank) for dots 252 to 455.
- R4: `mode` is 1 (vertical blank) on every dot of lines 144 to 153. A frame is 154 lines, so 70,224 ticks separate consecutive `frame_end_pulse` strobes.
- R5: `vram_busy` is high exactly when `mode` is 3.
- R6: During the first 160 dots of pixel transfer, `col_valid` is 1 and `col` counts from 0 to 159. At every other time, `col_valid` is 0 and `col` is 0.
- R7: `hblank_pulse` is high for one clock in the first cycle of horizontal blank on each visible line. In that cycle, `line` shows the current line.
- R8: `vblank_pulse` is high for one clock in the first cycle of line 144.
- R9: `frame_end_pulse` is high for one clock in the first cycle after line 153 wraps back to line 0.
- R10: The counters move only on clock edges where `tick` is high. When `tick` is low, every output except the strobes holds its value, and the strobes are 0.
- R11: While `lcd_on` is low, the following hold from the next clock edge. The counters are held at 0, `mode` is 0, `col_valid` and `vram_busy` are 0, and no strobe fires. When `lcd_on` is raised, line 0 starts at dot 0 with `mode` 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | CPU clock enable; one dot per high cycle |
| lcd_on | input | 1 | Display enable; low holds the sequencer at the origin |
| mode | output | 2 | Phase: 0 hblank, 1 vblank, 2 object search, 3 pixel transfer |
| line | output | 8 | Current line, 0 to 153 |
| col | output | 8 | Pixel column during transfer, 0 otherwise |
| col_valid | output | 1 | `col` carries a visible column |
| vram_busy | output | 1 | VRAM locked against CPU access |
| hblank_pulse | output | 1 | One-cycle strobe on entry to horizontal blank |
| vblank_pulse | output | 1 | One-cycle strobe on entry to vertical blank (frame ready) |
| frame_end_pulse | output | 1 | One-cycle strobe on wrap to line 0 |

## Verification
The bench targets the phase boundaries at dots 79/80, 251/252 and 455/0.

- If a comparison is off by one, a phase starts a dot early or late. That also shifts the VRAM lock, so the CPU is locked out while horizontal blank has already begun.
- Line 143 to 144 and line 153 to 0 are checked by counting ticks between frame strobes. A wrong wrap gives a frame of 153 or 155 lines.
- A stretch with `tick` gated exposes strobes that repeat while the counter is held, and counters that run on the raw clock.
- Dropping `lcd_on` in the middle of a line shows whether the counters keep stale state, rather than restarting line 0 in object search.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  typedef enum logic [1:0] {
    PH_HBLANK = 2'd0,
    PH_VBLANK = 2'd1,
    PH_SEARCH = 2'd2,
    PH_XFER   = 2'd3
  } lcd_phase_e;

  // Phase of a given dot on a given line
  function automatic lcd_phase_e phase_at(int unsigned dot, int unsigned line,
                                          int unsigned vis_lines,
                                          int unsigned srch_cyc,
                                          int unsigned xfer_cyc);
    if (line >= vis_lines)             return PH_VBLANK;
    if (dot < srch_cyc)                return PH_SEARCH;
    if (dot < srch_cyc + xfer_cyc)     return PH_XFER;
    return PH_HBLANK;
  endfunction

  // Whether a dot falls inside the visible-column window of transfer
  function automatic logic col_window(int unsigned dot, int unsigned srch_cyc,
                                      int unsigned width);
    return (dot >= srch_cyc) && (dot < srch_cyc + width);
  endfunction

  // Pixel column of a dot inside transfer
  function automatic int unsigned column_at(int unsigned dot, int unsigned srch_cyc);
    return dot - srch_cyc;
  endfunction

endpackage

// File: rtl/lseq_timebase.sv
module lseq_timebase #(
  parameter int unsigned LINE_CYC = 456,
  parameter int unsigned V_TOTAL  = 154,
  localparam int unsigned DOT_W   = $clog2(LINE_CYC),
  localparam int unsigned LINE_W  = $clog2(V_TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  output logic [DOT_W-1:0]  dot,
  output logic [LINE_W-1:0] line,
  output logic [DOT_W-1:0]  nxt_dot,
  output logic [LINE_W-1:0] nxt_line,
  output logic              step
);

  logic [DOT_W-1:0]  dot_q;
  logic [LINE_W-1:0] line_q;
  logic              last_dot, last_line;

  always_comb begin
    last_dot  = (dot_q == DOT_W'(LINE_CYC - 1));
    last_line = (line_q == LINE_W'(V_TOTAL - 1));
    nxt_dot   = last_dot ? '0 : dot_q + 1'b1;
    if (!last_dot)      nxt_line = line_q;
    else if (last_line) nxt_line = '0;
    else                nxt_line = line_q + 1'b1;
    step      = run && tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q  <= '0;
      line_q <= '0;
    end else if (!run) begin
      dot_q  <= '0;
      line_q <= '0;
    end else if (tick) begin
      dot_q  <= nxt_dot;
      line_q <= nxt_line;
    end
  end

  assign dot  = dot_q;
  assign line = line_q;

  // R2
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_dot) |=> (dot_q == '0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> ($stable(dot_q) && $stable(line_q)));

  // R11
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (dot_q == '0 && line_q == '0));

endmodule

// File: rtl/lseq_phase.sv
module lseq_phase
  import lcdseq_pkg::*;
#(
  parameter int unsigned H_PIXELS  = 160,
  parameter int unsigned V_LINES   = 144,
  parameter int unsigned SRCH_CYC  = 80,
  parameter int unsigned XFER_CYC  = 172,
  parameter int unsigned DOT_W     = 9,
  parameter int unsigned LINE_W    = 8,
  localparam int unsigned COL_W    = $clog2(H_PIXELS)
) (
  input  logic              run,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  output lcd_phase_e        phase,
  output logic [COL_W-1:0]  col,
  output logic              col_valid,
  output logic              busy
);

  always_comb begin
    phase     = run ? phase_at(32'(dot), 32'(line), V_LINES, SRCH_CYC, XFER_CYC)
                    : PH_HBLANK;
    col_valid = (phase == PH_XFER) && col_window(32'(dot), SRCH_CYC, H_PIXELS);
    col       = col_valid ? COL_W'(column_at(32'(dot), SRCH_CYC)) : '0;
    busy      = (phase == PH_XFER);
  end

endmodule

// File: rtl/lseq_events.sv
module lseq_events #(
  parameter int unsigned V_LINES  = 144,
  parameter int unsigned HB_START = 252,
  parameter int unsigned DOT_W    = 9,
  parameter int unsigned LINE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [DOT_W-1:0]  nxt_dot,
  input  logic [LINE_W-1:0] nxt_line,
  output logic              hb_pulse,
  output logic              vb_pulse,
  output logic              fe_pulse
);

  logic enter_hb, enter_vb, enter_fe;

  always_comb begin
    enter_hb = step && (nxt_dot == DOT_W'(HB_START)) && (nxt_line < LINE_W'(V_LINES));
    enter_vb = step && (nxt_dot == '0) && (nxt_line == LINE_W'(V_LINES));
    enter_fe = step && (nxt_dot == '0) && (nxt_line == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_pulse <= 1'b0;
      vb_pulse <= 1'b0;
      fe_pulse <= 1'b0;
    end else begin
      hb_pulse <= enter_hb;
      vb_pulse <= enter_vb;
      fe_pulse <= enter_fe;
    end
  end

  // R7
  hb_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_pulse |=> !hb_pulse);

  // R8
  vb_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vb_pulse |=> !vb_pulse);

  // R9
  fe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_pulse |=> !fe_pulse);

  // R11
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $countones({hb_pulse, vb_pulse, fe_pulse}) == 0);

endmodule

// File: rtl/lcd_line_sequencer.sv
module lcd_line_sequencer
  import lcdseq_pkg::*;
#(
  parameter int unsigned H_PIXELS    = 160,
  parameter int unsigned V_LINES     = 144,
  parameter int unsigned VBLANK_LINES = 10,
  parameter int unsigned SRCH_CYC    = 80,
  parameter int unsigned XFER_CYC    = 172,
  parameter int unsigned LINE_CYC    = 456
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   tick,
  input  logic                                   lcd_on,
  output logic [1:0]                             mode,
  output logic [$clog2(V_LINES+VBLANK_LINES)-1:0] line,
  output logic [$clog2(H_PIXELS)-1:0]            col,
  output logic                                   col_valid,
  output logic                                   vram_busy,
  output logic                                   hblank_pulse,
  output logic                                   vblank_pulse,
  output logic                                   frame_end_pulse
);

  localparam int unsigned V_TOTAL  = V_LINES + VBLANK_LINES;
  localparam int unsigned DOT_W    = $clog2(LINE_CYC);
  localparam int unsigned LINE_W   = $clog2(V_TOTAL);
  localparam int unsigned HB_START = SRCH_CYC + XFER_CYC;

  logic [DOT_W-1:0]  dot, nxt_dot;
  logic [LINE_W-1:0] nxt_line;
  logic              step;
  lcd_phase_e        phase;

  lseq_timebase #(.LINE_CYC(LINE_CYC), .V_TOTAL(V_TOTAL)) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(lcd_on),
    .dot(dot), .line(line), .nxt_dot(nxt_dot), .nxt_line(nxt_line), .step(step)
  );

  lseq_phase #(
    .H_PIXELS(H_PIXELS), .V_LINES(V_LINES), .SRCH_CYC(SRCH_CYC),
    .XFER_CYC(XFER_CYC), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_phase (
    .run(lcd_on), .dot(dot), .line(line), .phase(phase),
    .col(col), .col_valid(col_valid), .busy(vram_busy)
  );

  lseq_events #(
    .V_LINES(V_LINES), .HB_START(HB_START), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_events (
    .clk(clk), .rst_n(rst_n), .step(step), .nxt_dot(nxt_dot), .nxt_line(nxt_line),
    .hb_pulse(hblank_pulse), .vb_pulse(vblank_pulse), .fe_pulse(frame_end_pulse)
  );

  assign mode = phase;

  // R6
  col_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> vram_busy);

  // R7
  hb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_pulse |-> (mode == 2'd0 && line < LINE_W'(V_LINES)));

  // R8
  vb_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_pulse |-> (line == LINE_W'(V_LINES) && mode == 2'd1));

  // R9
  fe_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_pulse |-> (line == '0 && mode == 2'd2));

  // R5
  busy_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_busy |-> (line < LINE_W'(V_LINES) && lcd_on));

endmodule

// File: tb/lcd_line_sequencer_bench.sv
module lcd_line_sequencer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       lcd_on = 1'b1;
  logic [1:0] mode;
  logic [7:0] line;
  logic [7:0] col;
  logic       col_valid, vram_busy, hblank_pulse, vblank_pulse, frame_end_pulse;

  always #2 clk = ~clk;

  lcd_line_sequencer u_lcd_line_sequencer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lcd_on(lcd_on),
    .mode(mode), .line(line), .col(col), .col_valid(col_valid),
    .vram_busy(vram_busy), .hblank_pulse(hblank_pulse),
    .vblank_pulse(vblank_pulse), .frame_end_pulse(frame_end_pulse)
  );

  int  tests = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  gated = 1'b0;
  int  rd = 0, rl = 0;
  bit  e_hb = 0, e_vb = 0, e_fe = 0;
  int  sb_q[$];
  int  ticks_since_fe = 0;
  bit  fe_seen_since_on = 0;
  int  cyc = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (line %0d dot %0d)", req, act, exp, rl, rd);
    end
  endtask

  // Reference model and driver side of the scoreboard
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd = 0; rl = 0; e_hb = 0; e_vb = 0; e_fe = 0;
      ticks_since_fe = 0;
    end else if (!lcd_on) begin
      rd = 0; rl = 0; e_hb = 0; e_vb = 0; e_fe = 0;
      ticks_since_fe = 0;
    end else begin
      e_hb = 0; e_vb = 0; e_fe = 0;
      if (tick) begin
        ticks_since_fe++;
        if (rd == 455) begin
          rd = 0;
          rl = (rl == 153) ? 0 : rl + 1;
          if (rl == 144) begin e_vb = 1; sb_q.push_back(2*256 + 144); end
          if (rl == 0)   begin e_fe = 1; sb_q.push_back(3*256 + 0); end
        end else begin
          rd = rd + 1;
          if (rd == 252 && rl < 144) begin e_hb = 1; sb_q.push_back(1*256 + rl); end
        end
      end
    end
  end

  function automatic int exp_mode();
    if (!lcd_on)  return 0;
    if (rl > 143) return 1;
    if (rd < 80)  return 2;
    if (rd < 252) return 3;
    return 0;
  endfunction

  // Monitor: compares every cycle away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      int em;
      bit ev;
      int ec;
      string rq;
      em = exp_mode();
      ev = lcd_on && rl < 144 && rd >= 80 && rd < 240;
      ec = ev ? rd - 80 : 0;
      if (!rst_n)                rq = "R1";
      else if (!lcd_on)          rq = "R11";
      else if (gated)            rq = "R10";
      else if (rl > 143)         rq = "R4";
      else                       rq = "R3";
      chk(mode == em[1:0], {rq, " mode"}, mode, em);
      chk(line == rl[7:0], (gated ? "R10 line" : (rst_n ? "R2 line" : "R1 line")), line, rl);
      chk(vram_busy == (em == 3), "R5 vram_busy", vram_busy, em == 3);
      chk(col_valid == ev, "R6 col_valid", col_valid, ev);
      chk(col == ec[7:0], "R6 col", col, ec);
      chk(hblank_pulse == e_hb, "R7 hblank_pulse", hblank_pulse, e_hb);
      chk(vblank_pulse == e_vb, "R8 vblank_pulse", vblank_pulse, e_vb);
      chk(frame_end_pulse == e_fe, "R9 frame_end_pulse", frame_end_pulse, e_fe);
      if (hblank_pulse || vblank_pulse || frame_end_pulse) begin
        int got;
        got = (hblank_pulse ? 1 : vblank_pulse ? 2 : 3) * 256 + int'(line);
        if (sb_q.size() == 0) chk(1'b0, "R7 scoreboard empty", got, -1);
        else begin
          int want;
          want = sb_q.pop_front();
          chk(got == want, "R8 scoreboard order", got, want);
        end
      end
      if (frame_end_pulse) begin
        // R4: full frame = 154 x 456 ticks
        chk(ticks_since_fe == 70224, "R4 frame length", ticks_since_fe, 70224);
        ticks_since_fe = 0;
      end
    end
  end

  task automatic run_ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick = 1'b1;
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1 tick = 1'b0;
      end
    end
    @(posedge clk); #1 tick = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state with the display enabled
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // Main pass: one full frame plus a few lines, tick every cycle (R2 R3 R4 R7 R8 R9)
    run_ticks(70224 + 1000, 0);
    // R10: gated tick, one tick every third cycle
    gated = 1'b1;
    run_ticks(600, 2);
    gated = 1'b0;
    // R11: drop enable in mid-line and hold it low
    run_ticks(30, 0);
    @(posedge clk); #1 lcd_on = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    chk(line == 8'd0 && mode == 2'd0, "R11 held at origin", {line, mode}, 0);
    lcd_on = 1'b1;
    @(negedge clk);
    chk(mode == 2'd2 && line == 8'd0, "R11 restart in search", mode, 2);
    // Run past a transfer and hblank on the restarted line
    run_ticks(1400, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    chk(sb_q.size() == 0, "R9 scoreboard drained", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule